// File: doc/BRIEF.md
# Field Memory Line Sequencer

This block is the timing generator that sits next to a video line-rate conversion pipeline. It produces the read-enable strobes for three field-memory input buses (A, C, E) and the write-enable strobes for two field-memory output buses (B, D). It also produces data-valid flags for the main pixel output (F) and the secondary pixel output (G). Every strobe is timed from the rising edge of a field-start input. Within each line, a strobe opens at a fixed base cycle plus a programmable shift. It stays open for a programmable number of active pixels.

The pipeline delays pixels by three lines. The output-valid flags therefore begin on line 3 of the field. The memory writes begin one line after that, on line 4. A pixel counter and a line counter are cleared on each field-start rising edge. The line counter stops at a programmable lines-per-field count, and all strobes are then idle until the next field start.

Line length, active length, lines per field and the three shift values are captured at field start. Two live enable bits gate parts of the output:
- one marks the presence of a third field memory, and gates bus E and bus D;
- one gates the G output.

Top module: `fmls_line_seq`

## Requirements
- R1: After reset, and until the first cycle in which `fld_start` is sampled high after being low, all seven strobe outputs are 0.
- R2: The clock edge at which `fld_start` is first sampled high is edge 0. Let L be the captured line length, N the captured active length, and p = (k mod L) for the period after edge k. `rd_c` is 1 exactly when 63+SC <= p < 63+SC+N, on every line of the field, where SC is the captured C/E shift.
- R3: `rd_a` is 1 exactly when 94+SA <= p < 94+SA+N on every line, where SA is the captured A shift.
- R4: `out_f_vld` is 1 exactly when 148 <= p < 148+N, and only on lines with index (k div L) of 3 or more.
- R5: `wr_b` is 1 exactly when 160+SB <= p < 160+SB+N, and only on lines with index 4 or more, where SB is the captured B/D shift.
- R6: `rd_e` equals `rd_c`, and `wr_d` equals `wr_b`, while `cfg_third_mem` is 1. Both are 0 while it is 0.
- R7: `out_g_vld` equals `out_f_vld` while `cfg_matrix_en` is 1, and is 0 while it is 0.
- R8: The line length, active length, lines-per-field and shift inputs are captured only at field start. Changing them during a field has no effect on that field's strobes.
- R9: Once the line index reaches the captured lines-per-field count, all strobes stay 0 until the next field start.
- R10: A new rising edge of `fld_start` in the middle of a field restarts the timing at edge 0. Holding `fld_start` high does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_start | input | 1 | Field-start enable; its rising edge defines cycle 0 |
| cfg_line_len | input | PIX_W | Clocks per line (at least 1) |
| cfg_active_len | input | PIX_W | Active pixels per strobe window |
| cfg_lines | input | LINE_W | Lines per field |
| cfg_shift_a | input | SHIFT_W | Extra delay of bus A read enable |
| cfg_shift_ce | input | SHIFT_W | Extra delay shared by bus C and bus E read enables |
| cfg_shift_bd | input | SHIFT_W | Extra delay shared by bus B and bus D write enables |
| cfg_third_mem | input | 1 | Third field memory present; enables bus E and bus D |
| cfg_matrix_en | input | 1 | Enables the secondary output valid |
| rd_a | output | 1 | Read enable, bus A |
| rd_c | output | 1 | Read enable, bus C |
| rd_e | output | 1 | Read enable, bus E |
| wr_b | output | 1 | Write enable, bus B |
| wr_d | output | 1 | Write enable, bus D |
| out_f_vld | output | 1 | Main output data valid |
| out_g_vld | output | 1 | Secondary output data valid |

## Verification
The strobes are decoded without a register from counters that are cleared at edge 0. A strobe with base O and shift S on line l is therefore high in the clock periods that follow edges l*L+O+S through l*L+O+S+N-1. It falls after edge l*L+O+S+N.

The bench raises `fld_start` at a falling edge. It then samples every output at each following falling edge k, with k=0 being the half period just after edge 0. It compares each sample with a model of this window formula that uses the configuration captured at the start. Mid-field configuration changes and restarts are applied at a falling edge, so the model's capture point matches the design's next rising edge.

// File: rtl/fmls_pkg.sv
package fmls_pkg;
   // Strobe groups sharing a base offset, a line delay and a shift
   localparam int GRP_A   = 0;
   localparam int GRP_CE  = 1;
   localparam int GRP_FG  = 2;
   localparam int GRP_BD  = 3;
   localparam int NUM_GRP = 4;
endpackage

// File: rtl/fmls_timebase.sv
module fmls_timebase #(
   parameter int PIX_W   = 12,
   parameter int LINE_W  = 10,
   parameter int SHIFT_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fld_start,
   input  logic [PIX_W-1:0]   cfg_line_len,
   input  logic [PIX_W-1:0]   cfg_active_len,
   input  logic [LINE_W-1:0]  cfg_lines,
   input  logic [SHIFT_W-1:0] cfg_shift_a,
   input  logic [SHIFT_W-1:0] cfg_shift_ce,
   input  logic [SHIFT_W-1:0] cfg_shift_bd,
   output logic [PIX_W-1:0]   pix,
   output logic [LINE_W-1:0]  line,
   output logic               live,
   output logic [PIX_W-1:0]   act_q,
   output logic [SHIFT_W-1:0] sh_a_q,
   output logic [SHIFT_W-1:0] sh_ce_q,
   output logic [SHIFT_W-1:0] sh_bd_q
);
   logic              fs_q;
   logic              run;
   logic              rise;
   logic              expired;
   logic              eol;
   logic [PIX_W-1:0]  len_q;
   logic [LINE_W-1:0] lines_q;

   assign rise    = fld_start & ~fs_q;
   assign expired = (line == lines_q);
   assign eol     = (pix == len_q - PIX_W'(1));
   assign live    = run & ~expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q    <= 1'b0;
         run     <= 1'b0;
         pix     <= '0;
         line    <= '0;
         len_q   <= '0;
         act_q   <= '0;
         lines_q <= '0;
         sh_a_q  <= '0;
         sh_ce_q <= '0;
         sh_bd_q <= '0;
      end else begin
         fs_q <= fld_start;
         if (rise) begin
            run     <= 1'b1;
            pix     <= '0;
            line    <= '0;
            len_q   <= cfg_line_len;
            act_q   <= cfg_active_len;
            lines_q <= cfg_lines;
            sh_a_q  <= cfg_shift_a;
            sh_ce_q <= cfg_shift_ce;
            sh_bd_q <= cfg_shift_bd;
         end else if (live) begin
            if (eol) begin
               pix  <= '0;
               line <= line + LINE_W'(1);
            end else begin
               pix  <= pix + PIX_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fmls_window.sv
module fmls_window #(
   parameter int PIX_W    = 12,
   parameter int LINE_W   = 10,
   parameter int SHIFT_W  = 5,
   parameter int BASE     = 63,
   parameter int LINE_DLY = 0
) (
   input  logic               live,
   input  logic [PIX_W-1:0]   pix,
   input  logic [LINE_W-1:0]  line,
   input  logic [SHIFT_W-1:0] shift,
   input  logic [PIX_W-1:0]   act_len,
   output logic               hit
);
   localparam int EXT_W = PIX_W + 2;

   logic [EXT_W-1:0] lo;
   logic [EXT_W-1:0] hi;
   logic [EXT_W-1:0] pix_x;
   logic             line_ok;

   assign lo    = EXT_W'(BASE) + EXT_W'(shift);
   assign hi    = lo + EXT_W'(act_len);
   assign pix_x = EXT_W'(pix);

   generate
      if (LINE_DLY == 0) begin : g_no_dly
         assign line_ok = 1'b1;
      end else begin : g_dly
         assign line_ok = (line >= LINE_W'(LINE_DLY));
      end
   endgenerate

   assign hit = live & line_ok & (pix_x >= lo) & (pix_x < hi);
endmodule

// File: rtl/fmls_line_seq.sv
module fmls_line_seq
   import fmls_pkg::*;
#(
   parameter int PIX_W    = 12,
   parameter int LINE_W   = 10,
   parameter int SHIFT_W  = 5,
   parameter int BASE_CE  = 63,
   parameter int BASE_A   = 94,
   parameter int BASE_FG  = 148,
   parameter int BASE_BD  = 160,
   parameter int DLY_FG   = 3,
   parameter int DLY_BD   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fld_start,
   input  logic [PIX_W-1:0]   cfg_line_len,
   input  logic [PIX_W-1:0]   cfg_active_len,
   input  logic [LINE_W-1:0]  cfg_lines,
   input  logic [SHIFT_W-1:0] cfg_shift_a,
   input  logic [SHIFT_W-1:0] cfg_shift_ce,
   input  logic [SHIFT_W-1:0] cfg_shift_bd,
   input  logic               cfg_third_mem,
   input  logic               cfg_matrix_en,
   output logic               rd_a,
   output logic               rd_c,
   output logic               rd_e,
   output logic               wr_b,
   output logic               wr_d,
   output logic               out_f_vld,
   output logic               out_g_vld
);
   localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
   localparam int PIX_SPAN  = 1 << PIX_W;

   generate
      if (BASE_BD + MAX_SHIFT >= PIX_SPAN) begin : g_bad_span
         $error("largest shifted base does not fit the pixel counter");
      end
      if (DLY_BD <= DLY_FG) begin : g_bad_dly
         $error("memory write must lag the output by at least one line");
      end
      if (DLY_BD >= (1 << LINE_W)) begin : g_bad_line
         $error("line counter too narrow for the write delay");
      end
   endgenerate

   logic [PIX_W-1:0]   pix;
   logic [LINE_W-1:0]  line;
   logic               live;
   logic [PIX_W-1:0]   act_q;
   logic [SHIFT_W-1:0] sh_a_q;
   logic [SHIFT_W-1:0] sh_ce_q;
   logic [SHIFT_W-1:0] sh_bd_q;
   logic [SHIFT_W-1:0] grp_shift [NUM_GRP];
   logic [NUM_GRP-1:0] grp_hit;

   fmls_timebase #(
      .PIX_W   (PIX_W),
      .LINE_W  (LINE_W),
      .SHIFT_W (SHIFT_W)
   ) u_tb (
      .clk            (clk),
      .rst_n          (rst_n),
      .fld_start      (fld_start),
      .cfg_line_len   (cfg_line_len),
      .cfg_active_len (cfg_active_len),
      .cfg_lines      (cfg_lines),
      .cfg_shift_a    (cfg_shift_a),
      .cfg_shift_ce   (cfg_shift_ce),
      .cfg_shift_bd   (cfg_shift_bd),
      .pix            (pix),
      .line           (line),
      .live           (live),
      .act_q          (act_q),
      .sh_a_q         (sh_a_q),
      .sh_ce_q        (sh_ce_q),
      .sh_bd_q        (sh_bd_q)
   );

   assign grp_shift[GRP_A]  = sh_a_q;
   assign grp_shift[GRP_CE] = sh_ce_q;
   assign grp_shift[GRP_FG] = '0;
   assign grp_shift[GRP_BD] = sh_bd_q;

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         localparam int B = (g == GRP_A)  ? BASE_A  :
                            (g == GRP_CE) ? BASE_CE :
                            (g == GRP_FG) ? BASE_FG : BASE_BD;
         localparam int D = (g == GRP_FG) ? DLY_FG  :
                            (g == GRP_BD) ? DLY_BD  : 0;
         fmls_window #(
            .PIX_W    (PIX_W),
            .LINE_W   (LINE_W),
            .SHIFT_W  (SHIFT_W),
            .BASE     (B),
            .LINE_DLY (D)
         ) u_win (
            .live    (live),
            .pix     (pix),
            .line    (line),
            .shift   (grp_shift[g]),
            .act_len (act_q),
            .hit     (grp_hit[g])
         );
      end
   endgenerate

   assign rd_a      = grp_hit[GRP_A];
   assign rd_c      = grp_hit[GRP_CE];
   assign rd_e      = grp_hit[GRP_CE] & cfg_third_mem;
   assign wr_b      = grp_hit[GRP_BD];
   assign wr_d      = grp_hit[GRP_BD] & cfg_third_mem;
   assign out_f_vld = grp_hit[GRP_FG];
   assign out_g_vld = grp_hit[GRP_FG] & cfg_matrix_en;
endmodule

// File: rtl/fmls_chk.sv
module fmls_chk (
   input logic clk,
   input logic rst_n,
   input logic fld_start,
   input logic rd_a,
   input logic rd_c,
   input logic rd_e,
   input logic wr_b,
   input logic wr_d,
   input logic out_f_vld,
   input logic out_g_vld
);
   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else if (fld_start) seen <= 1'b1;
   end

   // R1
   idle_before_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> !(rd_a | rd_c | rd_e | wr_b | wr_d | out_f_vld | out_g_vld));

   // R6
   e_needs_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_e |-> rd_c);

   // R6
   d_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_d |-> wr_b);

   // R7
   g_needs_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_g_vld |-> out_f_vld);

   // R10
   new_field_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fld_start) |=> !(wr_b | out_f_vld));
endmodule

bind fmls_line_seq fmls_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fld_start (fld_start),
   .rd_a      (rd_a),
   .rd_c      (rd_c),
   .rd_e      (rd_e),
   .wr_b      (wr_b),
   .wr_d      (wr_d),
   .out_f_vld (out_f_vld),
   .out_g_vld (out_g_vld)
);

// File: tb/tb_fmls_line_seq.sv
`timescale 1ns/1ps
module tb_fmls_line_seq;
   localparam int PIX_W = 12, LINE_W = 10, SHIFT_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fld_start = 1'b0;
   logic [PIX_W-1:0]   cfg_line_len = 200, cfg_active_len = 20;
   logic [LINE_W-1:0]  cfg_lines = 6;
   logic [SHIFT_W-1:0] cfg_shift_a = 0, cfg_shift_ce = 0, cfg_shift_bd = 0;
   logic cfg_third_mem = 1'b1, cfg_matrix_en = 1'b1;
   logic rd_a, rd_c, rd_e, wr_b, wr_d, out_f_vld, out_g_vld;

   int n_tests = 0, n_fail = 0;
   int m_len, m_act, m_lpf, m_sa, m_sce, m_sbd;

   always #4 clk = ~clk;

   fmls_line_seq dut (
      .clk(clk), .rst_n(rst_n), .fld_start(fld_start),
      .cfg_line_len(cfg_line_len), .cfg_active_len(cfg_active_len),
      .cfg_lines(cfg_lines), .cfg_shift_a(cfg_shift_a),
      .cfg_shift_ce(cfg_shift_ce), .cfg_shift_bd(cfg_shift_bd),
      .cfg_third_mem(cfg_third_mem), .cfg_matrix_en(cfg_matrix_en),
      .rd_a(rd_a), .rd_c(rd_c), .rd_e(rd_e), .wr_b(wr_b), .wr_d(wr_d),
      .out_f_vld(out_f_vld), .out_g_vld(out_g_vld)
   );

   function automatic string oname(int i);
      case (i)
         0: return "rd_a R3";
         1: return "rd_c R2";
         2: return "rd_e R6";
         3: return "wr_b R5";
         4: return "wr_d R6";
         5: return "out_f_vld R4";
         default: return "out_g_vld R7";
      endcase
   endfunction

   function automatic logic [6:0] outs();
      return {out_g_vld, out_f_vld, wr_d, wr_b, rd_e, rd_c, rd_a};
   endfunction

   function automatic bit win(int p, int ln, int o, int d);
      return (ln >= d) && (p >= o) && (p < o + m_act);
   endfunction

   // rel < 0 means no field started yet
   function automatic logic [6:0] model(int rel);
      logic [6:0] e = '0;
      int p, ln;
      if (rel < 0) return e;
      p  = rel % m_len;
      ln = rel / m_len;
      if (ln >= m_lpf) return e;
      e[0] = win(p, ln, 94 + m_sa, 0);
      e[1] = win(p, ln, 63 + m_sce, 0);
      e[2] = e[1] & cfg_third_mem;
      e[3] = win(p, ln, 160 + m_sbd, 4);
      e[4] = e[3] & cfg_third_mem;
      e[5] = win(p, ln, 148, 3);
      e[6] = e[5] & cfg_matrix_en;
      return e;
   endfunction

   task automatic capture_model();
      m_len = cfg_line_len;  m_act = cfg_active_len; m_lpf = cfg_lines;
      m_sa = cfg_shift_a;    m_sce = cfg_shift_ce;   m_sbd = cfg_shift_bd;
   endtask

   // start: raise fld_start at k=0 (-1 means none); chg_at: alter config;
   // restart_at: raise a second edge mid-field
   task automatic run_scn(string scen, bit start, int ncyc, int chg_at, int restart_at);
      int errs [7];
      int fk [7];
      logic [6:0] fg [7];
      logic [6:0] fe [7];
      int base;
      base = -1;
      for (int i = 0; i < 7; i++) errs[i] = 0;
      @(negedge clk);
      if (start) begin
         fld_start = 1'b1;
         capture_model();
         base = 0;
      end
      for (int k = 0; k < ncyc; k++) begin
         logic [6:0] got, exp;
         @(negedge clk);
         got = outs();
         exp = model(base < 0 ? -1 : k - base);
         for (int i = 0; i < 7; i++) begin
            if (got[i] !== exp[i]) begin
               if (errs[i] == 0) begin fk[i] = k; fg[i] = got; fe[i] = exp; end
               errs[i]++;
            end
         end
         if (base >= 0 && k - base == 3) fld_start = 1'b0;
         if (k == chg_at) begin
            cfg_shift_a = 11; cfg_shift_ce = 7; cfg_shift_bd = 3;
            cfg_line_len = 180; cfg_active_len = 9; cfg_lines = 2;
         end
         if (k == restart_at) begin
            fld_start = 1'b1;
            capture_model();
            base = k + 1;
         end
      end
      fld_start = 1'b0;
      for (int i = 0; i < 7; i++) begin
         n_tests++;
         if (errs[i] != 0) begin
            n_fail++;
            $display("FAIL %s [%s] cycle %0d: got %b expected %b",
                     oname(i), scen, fk[i], fg[i][i], fe[i][i]);
         end
      end
   endtask

   task automatic set_cfg(int len, int act, int lpf, int sa, int sce, int sbd, bit t3, bit mx);
      cfg_line_len = PIX_W'(len); cfg_active_len = PIX_W'(act); cfg_lines = LINE_W'(lpf);
      cfg_shift_a = SHIFT_W'(sa); cfg_shift_ce = SHIFT_W'(sce); cfg_shift_bd = SHIFT_W'(sbd);
      cfg_third_mem = t3; cfg_matrix_en = mx;
   endtask

   task automatic t_reset_idle();    // R1
      run_scn("R1 idle after reset", 1'b0, 300, -1, -1);
   endtask

   task automatic t_basic();         // R2 R3 R4 R5 R9
      set_cfg(200, 20, 6, 0, 0, 0, 1'b1, 1'b1);
      run_scn("R9 basic field and expiry", 1'b1, 1300, -1, -1);
   endtask

   task automatic t_shifts();        // R2 R3 R5
      set_cfg(200, 17, 6, 9, 5, 13, 1'b1, 1'b1);
      run_scn("shifted strobes", 1'b1, 1300, -1, -1);
   endtask

   task automatic t_gates();         // R6 R7
      set_cfg(200, 20, 6, 2, 4, 6, 1'b0, 1'b0);
      run_scn("gated buses", 1'b1, 1300, -1, -1);
   endtask

   task automatic t_midfield_cfg();  // R8
      set_cfg(200, 20, 6, 1, 2, 3, 1'b1, 1'b1);
      run_scn("R8 mid-field config change", 1'b1, 1300, 250, -1);
   endtask

   task automatic t_restart();       // R10
      set_cfg(200, 20, 6, 4, 8, 12, 1'b1, 1'b1);
      run_scn("R10 restart mid-field", 1'b1, 1700, -1, 450);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset_idle();
      t_basic();
      t_shifts();
      t_gates();
      t_midfield_cfg();
      t_restart();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule